// File: doc/BRIEF.md
# Config-Space Data Object Mailbox

This block is the device-side register set of a mailbox that moves whole data objects between a host and a local responder. The host reaches it through a plain 32-bit configuration read/write port addressed by a byte offset inside the capability. The host pushes request dwords one by one into a write mailbox, then sets a go bit. If the header is consistent, the block hands the gathered object to the responder port. The responder reads the request dwords by index and pushes its reply dwords back.

The host then drains the reply through a read mailbox. Reading that mailbox never changes it: the next dword appears only after the host writes any value to the read mailbox. Status flags report busy, error, data-object-ready and a pending interrupt. An abort command returns the mailbox to idle within one clock, whatever state it was stuck in. When interrupts are enabled, the block raises an interrupt request when a reply becomes ready and when an abort completes.

Top module: `dobj_mailbox`

## Requirements
- R1: After reset the control, status and read-mailbox words read zero and `irq` is low. The capability word at offset 0x04 reports interrupt support in bit 0 and the interrupt message number in bits 11:1.
- R2: The control word is at offset 0x08, the status word at 0x0C, the write mailbox at 0x10 and the read mailbox at 0x14. Any other offset, and the write mailbox itself, reads zero. The control word reads back only the interrupt enable, in bit 1.
- R3: A go command (control bit 31) is accepted when the mailbox is idle and the object is consistent. It pulses `req_start` for one cycle and sets busy (status bit 0). `req_words` then equals the number of dwords written. `req_rd_data` returns those dwords by index in write order. Bits 15:0 and 23:16 of the first dword appear on `hdr_vendor` and `hdr_type`.
- R4: An object is consistent when it holds at least two dwords and bits 17:0 of its second dword equal the number of dwords written. A go on an inconsistent object sets error (status bit 2) and does not start the responder.
- R5: Error is set by a write to the write mailbox while busy, and by a write beyond REQ_DEPTH dwords. Error stays set until an abort, and a go issued while error is set has no effect.
- R6: While busy, each `rsp_valid` cycle stores `rsp_data`. The cycle that also carries `rsp_last` clears busy and sets data-object-ready (status bit 31). Busy and ready are never set together.
- R7: A read of the read mailbox returns the current reply dword and does not advance it; a write of any value advances it. After the last dword is passed, ready clears. A read while not ready returns zero.
- R8: Interrupt status (status bit 1) is set when ready rises, or when an abort completes, only if interrupt enable (control bit 1) is set. Writing a one to status bit 1 clears it, and writing a zero there has no effect. `irq` equals interrupt status AND interrupt enable.
- R9: An abort (control bit 0) clears busy, error, ready and the gathered request in the next cycle, even while busy. It pulses `mbx_abort` for one cycle, and responder pushes in the abort cycle or afterwards are ignored.
- R10: A go while busy, or while a reply is still ready, sets error and does not pulse `req_start`.
- R11: Reply dwords beyond RSP_DEPTH are dropped. The host then drains exactly RSP_DEPTH dwords.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Byte offset inside the capability |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| req_start | output | 1 | One-cycle pulse when a request is handed over |
| req_words | output | $clog2(REQ_DEPTH+1) | Dword count of the handed-over request |
| hdr_vendor | output | 16 | Vendor field of the first request dword |
| hdr_type | output | 8 | Object type field of the first request dword |
| req_rd_idx | input | $clog2(REQ_DEPTH) | Request dword index for the responder |
| req_rd_data | output | 32 | Request dword at `req_rd_idx` |
| rsp_valid | input | 1 | Responder pushes a reply dword |
| rsp_data | input | 32 | Reply dword |
| rsp_last | input | 1 | Marks the final reply dword |
| mbx_abort | output | 1 | One-cycle pulse telling the responder to drop its work |
| irq | output | 1 | Interrupt request level |

## Verification
The main exchange is swept over every request length from two dwords to REQ_DEPTH, crossed with every reply length from one to RSP_DEPTH+1. The request payload and reply words are computed from the two lengths, so a swapped index, a lost dword or an off-by-one in ready clearing gives a distinct mismatch. The longest replies tell saturation apart from wrap-around. Interrupt enable alternates across the sweep, which separates an interrupt that follows ready from one that ignores the enable. Directed cases then cover header-length mismatch, a one-dword object, request overflow, writes and go while busy, go while a reply is pending, and an abort issued mid-exchange.

// File: rtl/dobj_pkg.sv
package dobj_pkg;
    localparam int ADDR_W = 8;
    localparam int LEN_W  = 18;

    localparam logic [ADDR_W-1:0] OFS_CAP  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_WMBX = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_RMBX = 8'h14;

    localparam int CTL_ABORT = 0;
    localparam int CTL_IEN   = 1;
    localparam int CTL_GO    = 31;

    localparam int ST_BUSY  = 0;
    localparam int ST_INT   = 1;
    localparam int ST_ERR   = 2;
    localparam int ST_READY = 31;
endpackage

// File: rtl/dobj_word_store.sv
// Dword storage with one write port and one combinational read port.
// DEPTH is expected to be a power of two.
module dobj_word_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dobj_hdr_check.sv
// Decides whether a gathered object may be handed to the responder.
module dobj_hdr_check #(
    parameter int CW = 4
) (
    input  logic [dobj_pkg::LEN_W-1:0] hdr_len,
    input  logic [CW-1:0]              count,
    output logic                       ok
);
    import dobj_pkg::*;

    always_comb begin
        ok = (count >= CW'(2)) && (hdr_len == LEN_W'(count));
    end
endmodule

// File: rtl/dobj_mailbox.sv
module dobj_mailbox #(
    parameter int REQ_DEPTH   = 8,
    parameter int RSP_DEPTH   = 8,
    parameter int IRQ_SUPPORT = 1,
    parameter int IRQ_MSG_NUM = 5,
    localparam int RCW = $clog2(REQ_DEPTH + 1),
    localparam int RIW = $clog2(REQ_DEPTH),
    localparam int SCW = $clog2(RSP_DEPTH + 1),
    localparam int SIW = $clog2(RSP_DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr_en,
    input  logic [7:0]     cfg_addr,
    input  logic [31:0]    cfg_wdata,
    output logic [31:0]    cfg_rdata,
    output logic           req_start,
    output logic [RCW-1:0] req_words,
    output logic [15:0]    hdr_vendor,
    output logic [7:0]     hdr_type,
    input  logic [RIW-1:0] req_rd_idx,
    output logic [31:0]    req_rd_data,
    input  logic           rsp_valid,
    input  logic [31:0]    rsp_data,
    input  logic           rsp_last,
    output logic           mbx_abort,
    output logic           irq
);
    import dobj_pkg::*;

    typedef struct packed {
        logic             busy;
        logic             err;
        logic             ready;
        logic             int_en;
        logic             int_st;
        logic             start;
        logic             abort_p;
        logic [RCW-1:0]   req_cnt;
        logic [RCW-1:0]   req_words;
        logic [SCW-1:0]   rsp_cnt;
        logic [SIW-1:0]   rd_ptr;
        logic [LEN_W-1:0] hdr_len;
        logic [15:0]      vendor;
        logic [7:0]       otype;
    } state_t;

    state_t     st_d, st_q;
    logic       req_we, rsp_we, hdr_ok;
    logic       wr_ctrl, wr_stat, wr_wmbx, wr_rmbx, abort_now;
    logic [31:0] rsp_rdata;

    dobj_word_store #(.DEPTH(REQ_DEPTH), .WIDTH(32)) u_req_store (
        .clk   (clk),
        .we    (req_we),
        .waddr (st_q.req_cnt[RIW-1:0]),
        .wdata (cfg_wdata),
        .raddr (req_rd_idx),
        .rdata (req_rd_data)
    );

    dobj_word_store #(.DEPTH(RSP_DEPTH), .WIDTH(32)) u_rsp_store (
        .clk   (clk),
        .we    (rsp_we),
        .waddr (st_q.rsp_cnt[SIW-1:0]),
        .wdata (rsp_data),
        .raddr (st_q.rd_ptr),
        .rdata (rsp_rdata)
    );

    dobj_hdr_check #(.CW(RCW)) u_hdr_check (
        .hdr_len (st_q.hdr_len),
        .count   (st_q.req_cnt),
        .ok      (hdr_ok)
    );

    always_comb begin
        wr_ctrl   = cfg_wr_en && (cfg_addr == OFS_CTRL);
        wr_stat   = cfg_wr_en && (cfg_addr == OFS_STAT);
        wr_wmbx   = cfg_wr_en && (cfg_addr == OFS_WMBX);
        wr_rmbx   = cfg_wr_en && (cfg_addr == OFS_RMBX);
        abort_now = wr_ctrl && cfg_wdata[CTL_ABORT];
    end

    always_comb begin
        st_d         = st_q;
        st_d.start   = 1'b0;
        st_d.abort_p = 1'b0;
        req_we       = 1'b0;
        rsp_we       = 1'b0;

        // Interrupt status: write one to clear.
        if (wr_stat && cfg_wdata[ST_INT]) begin
            st_d.int_st = 1'b0;
        end

        // Request gathering.
        if (wr_wmbx) begin
            if (st_q.busy || (st_q.req_cnt == RCW'(REQ_DEPTH))) begin
                st_d.err = 1'b1;
            end else if (!st_q.err) begin
                req_we       = 1'b1;
                st_d.req_cnt = st_q.req_cnt + RCW'(1);
                if (st_q.req_cnt == RCW'(0)) begin
                    st_d.vendor = cfg_wdata[15:0];
                    st_d.otype  = cfg_wdata[23:16];
                end
                if (st_q.req_cnt == RCW'(1)) begin
                    st_d.hdr_len = cfg_wdata[LEN_W-1:0];
                end
            end
        end

        // Reply draining: a write advances, a read never does.
        if (wr_rmbx && st_q.ready) begin
            if (SCW'(st_q.rd_ptr) + SCW'(1) == st_q.rsp_cnt) begin
                st_d.ready   = 1'b0;
                st_d.rd_ptr  = '0;
                st_d.rsp_cnt = '0;
            end else begin
                st_d.rd_ptr = st_q.rd_ptr + SIW'(1);
            end
        end

        // Responder pushes.
        if (st_q.busy && rsp_valid && !abort_now) begin
            if (st_q.rsp_cnt != SCW'(RSP_DEPTH)) begin
                rsp_we       = 1'b1;
                st_d.rsp_cnt = st_q.rsp_cnt + SCW'(1);
            end
            if (rsp_last) begin
                st_d.busy  = 1'b0;
                st_d.ready = 1'b1;
                if (st_q.int_en) begin
                    st_d.int_st = 1'b1;
                end
            end
        end

        // Control: abort beats go.
        if (wr_ctrl) begin
            st_d.int_en = cfg_wdata[CTL_IEN];
            if (abort_now) begin
                st_d.busy    = 1'b0;
                st_d.err     = 1'b0;
                st_d.ready   = 1'b0;
                st_d.req_cnt = '0;
                st_d.rsp_cnt = '0;
                st_d.rd_ptr  = '0;
                st_d.abort_p = 1'b1;
                if (cfg_wdata[CTL_IEN]) begin
                    st_d.int_st = 1'b1;
                end
            end else if (cfg_wdata[CTL_GO]) begin
                if (st_q.busy || st_q.ready) begin
                    st_d.err = 1'b1;
                end else if (!st_q.err) begin
                    if (hdr_ok) begin
                        st_d.busy      = 1'b1;
                        st_d.start     = 1'b1;
                        st_d.req_words = st_q.req_cnt;
                        st_d.req_cnt   = '0;
                        st_d.rsp_cnt   = '0;
                        st_d.rd_ptr    = '0;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (cfg_addr)
            OFS_CAP:  cfg_rdata = {20'h0, 11'(IRQ_MSG_NUM), 1'(IRQ_SUPPORT)};
            OFS_CTRL: cfg_rdata = {30'h0, st_q.int_en, 1'b0};
            OFS_STAT: cfg_rdata = {st_q.ready, 28'h0, st_q.err, st_q.int_st, st_q.busy};
            OFS_RMBX: cfg_rdata = st_q.ready ? rsp_rdata : 32'h0;
            default:  cfg_rdata = 32'h0;
        endcase
    end

    assign req_start  = st_q.start;
    assign req_words  = st_q.req_words;
    assign hdr_vendor = st_q.vendor;
    assign hdr_type   = st_q.otype;
    assign mbx_abort  = st_q.abort_p;
    assign irq        = st_q.int_st & st_q.int_en;

    // Flags brought out for the bound checker.
    logic busy_w, err_w, ready_w, int_en_w;
    assign busy_w   = st_q.busy;
    assign err_w    = st_q.err;
    assign ready_w  = st_q.ready;
    assign int_en_w = st_q.int_en;
endmodule

// File: rtl/dobj_mailbox_chk.sv
module dobj_mailbox_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic [7:0]  cfg_addr,
    input logic [31:0] cfg_wdata,
    input logic        rsp_valid,
    input logic        rsp_last,
    input logic        req_start,
    input logic        irq,
    input logic        busy,
    input logic        err,
    input logic        ready,
    input logic        int_en
);
    import dobj_pkg::*;

    logic ctrl_wr, abort_wr;
    assign ctrl_wr  = cfg_wr_en && (cfg_addr == OFS_CTRL);
    assign abort_wr = ctrl_wr && cfg_wdata[CTL_ABORT];

    p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_wr |=> (!busy && !err && !ready));

    p_start_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_start |-> (busy && !$past(busy)));

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !abort_wr) |=> err);

    p_irq_on_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rsp_valid && rsp_last && int_en && !ctrl_wr) |=> irq);

    p_busy_ready_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && ready));

    p_ready_needs_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(rsp_valid && rsp_last));
endmodule

bind dobj_mailbox dobj_mailbox_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .rsp_valid (rsp_valid),
    .rsp_last  (rsp_last),
    .req_start (req_start),
    .irq       (irq),
    .busy      (busy_w),
    .err       (err_w),
    .ready     (ready_w),
    .int_en    (int_en_w)
);

// File: tb/dobj_mailbox_tb.sv
module dobj_mailbox_tb;
    localparam int CLK_PERIOD = 10;
    localparam int REQ_DEPTH  = 8;
    localparam int RSP_DEPTH  = 8;
    localparam int RCW = $clog2(REQ_DEPTH + 1);
    localparam int RIW = $clog2(REQ_DEPTH);

    localparam logic [7:0] A_CAP = 8'h04, A_CTRL = 8'h08, A_STAT = 8'h0C,
                           A_WMBX = 8'h10, A_RMBX = 8'h14;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_wr_en = 1'b0;
    logic [7:0]     cfg_addr = '0;
    logic [31:0]    cfg_wdata = '0;
    logic [31:0]    cfg_rdata;
    logic           req_start;
    logic [RCW-1:0] req_words;
    logic [15:0]    hdr_vendor;
    logic [7:0]     hdr_type;
    logic [RIW-1:0] req_rd_idx = '0;
    logic [31:0]    req_rd_data;
    logic           rsp_valid = 1'b0;
    logic [31:0]    rsp_data = '0;
    logic           rsp_last = 1'b0;
    logic           mbx_abort;
    logic           irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dobj_mailbox #(.REQ_DEPTH(REQ_DEPTH), .RSP_DEPTH(RSP_DEPTH),
                   .IRQ_SUPPORT(1), .IRQ_MSG_NUM(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_start(req_start),
        .req_words(req_words), .hdr_vendor(hdr_vendor), .hdr_type(hdr_type),
        .req_rd_idx(req_rd_idx), .req_rd_data(req_rd_data), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_last(rsp_last), .mbx_abort(mbx_abort), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic push(input logic [31:0] d, input logic last);
        @(negedge clk);
        rsp_valid = 1'b1;
        rsp_data  = d;
        rsp_last  = last;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_last  = 1'b0;
    endtask

    function automatic logic [31:0] stat(input bit b, input bit i, input bit e, input bit r);
        return {r, 28'h0, e, i, b};
    endfunction

    function automatic logic [31:0] req_word(input int n, input int k);
        if (k == 0) return {8'h00, 8'(n * 3), 16'h1E00 + 16'(n)};
        if (k == 1) return 32'(n);
        return 32'hA000_0000 + 32'(n * 16 + k);
    endfunction

    function automatic logic [31:0] rsp_word(input int m, input int j);
        return 32'h5000_0000 + 32'(m * 256 + j);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and capability word
        rd(A_CAP, v);  chk("R1 cap", v, 32'h0000_000B);
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        rd(A_STAT, v); chk("R1 status", v, 32'h0);
        rd(A_RMBX, v); chk("R1 rmbx", v, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        // R2 unmapped offsets and write mailbox read zero
        rd(8'h00, v);  chk("R2 ofs00", v, 32'h0);
        rd(8'h18, v);  chk("R2 ofs18", v, 32'h0);
        wr(A_CTRL, 32'hFFFF_FFFE & ~32'h8000_0000);
        rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'h2);
        wr(A_CTRL, 32'h0);

        // Sweep of request and reply lengths: R3 R6 R7 R8 R11
        for (int n = 2; n <= REQ_DEPTH; n++) begin
            for (int m = 1; m <= RSP_DEPTH + 1; m++) begin
                int  mm;
                bit  ien;
                ien = ((n + m) % 2) == 1;
                mm  = (m > RSP_DEPTH) ? RSP_DEPTH : m;
                wr(A_CTRL, {30'h0, ien, 1'b0});
                for (int k = 0; k < n; k++) wr(A_WMBX, req_word(n, k));
                rd(A_WMBX, v); chk("R2 wmbx reads zero", v, 32'h0);
                wr(A_CTRL, {1'b1, 29'h0, ien, 1'b0});
                chk("R3 req_start", 32'(req_start), 32'h1);
                chk("R3 req_words", 32'(req_words), 32'(n));
                chk("R3 vendor", 32'(hdr_vendor), 32'(16'h1E00 + 16'(n)));
                chk("R3 type", 32'(hdr_type), 32'(8'(n * 3)));
                rd(A_STAT, v); chk("R3 busy", v, stat(1, 0, 0, 0));
                for (int k = 0; k < n; k++) begin
                    req_rd_idx = RIW'(k);
                    #1;
                    chk("R3 request dword", req_rd_data, req_word(n, k));
                end
                for (int j = 0; j < m; j++) begin
                    push(rsp_word(m, j), j == m - 1);
                    if (j < m - 1) begin
                        rd(A_STAT, v); chk("R6 busy during reply", v, stat(1, 0, 0, 0));
                    end
                end
                rd(A_STAT, v); chk("R6 ready after last", v, stat(0, ien, 0, 1));
                chk("R8 irq follows enable", 32'(irq), 32'(ien));
                if (ien) begin
                    wr(A_STAT, 32'h0);
                    chk("R8 write zero keeps irq", 32'(irq), 32'h1);
                    wr(A_STAT, 32'h2);
                    chk("R8 w1c clears irq", 32'(irq), 32'h0);
                end
                for (int j = 0; j < mm; j++) begin
                    rd(A_RMBX, v); chk("R7 reply dword", v, rsp_word(m, j));
                    rd(A_RMBX, v); chk("R7 read does not advance", v, rsp_word(m, j));
                    wr(A_RMBX, 32'h0);
                end
                rd(A_STAT, v); chk("R11 ready cleared after drain", v, 32'h0);
                rd(A_RMBX, v); chk("R7 rmbx zero when idle", v, 32'h0);
            end
        end
        wr(A_CTRL, 32'h0);

        // R4 length mismatch
        wr(A_WMBX, req_word(3, 0));
        wr(A_WMBX, 32'd4);
        wr(A_WMBX, 32'h1234);
        wr(A_CTRL, 32'h8000_0000);
        chk("R4 no start on mismatch", 32'(req_start), 32'h0);
        rd(A_STAT, v); chk("R4 error on mismatch", v, stat(0, 0, 1, 0));
        wr(A_CTRL, 32'h1);
        rd(A_STAT, v); chk("R9 abort clears error", v, 32'h0);
        chk("R9 abort pulse", 32'(mbx_abort), 32'h1);
        chk("R8 no irq when disabled", 32'(irq), 32'h0);
        // R4 one-dword object
        wr(A_WMBX, 32'h1);
        wr(A_CTRL, 32'h8000_0000);
        chk("R4 no start on short object", 32'(req_start), 32'h0);
        rd(A_STAT, v); chk("R4 error on short object", v, stat(0, 0, 1, 0));
        wr(A_CTRL, 32'h1);

        // R5 overflow, then go ignored while error
        for (int k = 0; k < REQ_DEPTH; k++) wr(A_WMBX, (k == 1) ? 32'(REQ_DEPTH) : 32'h77);
        rd(A_STAT, v); chk("R5 full buffer no error", v, 32'h0);
        wr(A_WMBX, 32'h99);
        rd(A_STAT, v); chk("R5 overflow error", v, stat(0, 0, 1, 0));
        wr(A_CTRL, 32'h8000_0000);
        chk("R5 go ignored under error", 32'(req_start), 32'h0);
        rd(A_STAT, v); chk("R5 error sticky", v, stat(0, 0, 1, 0));
        wr(A_CTRL, 32'h1);

        // R5 / R10 / R9 while busy
        wr(A_WMBX, req_word(2, 0));
        wr(A_WMBX, 32'd2);
        wr(A_CTRL, 32'h8000_0002);
        chk("R3 start with irq enabled", 32'(req_start), 32'h1);
        wr(A_WMBX, 32'h55);
        rd(A_STAT, v); chk("R5 write while busy", v, stat(1, 0, 1, 0));
        wr(A_CTRL, 32'h8000_0002);
        chk("R10 no start while busy", 32'(req_start), 32'h0);
        wr(A_CTRL, 32'h3);
        chk("R9 abort pulse while busy", 32'(mbx_abort), 32'h1);
        rd(A_STAT, v); chk("R9 abort while busy", v, stat(0, 1, 0, 0));
        chk("R8 irq on abort", 32'(irq), 32'h1);
        push(32'hDEAD, 1'b1);
        rd(A_STAT, v); chk("R9 push after abort ignored", v, stat(0, 1, 0, 0));
        wr(A_STAT, 32'h2);
        chk("R8 cleared", 32'(irq), 32'h0);

        // R10 go while a reply is pending
        wr(A_CTRL, 32'h0);
        wr(A_WMBX, req_word(2, 0));
        wr(A_WMBX, 32'd2);
        wr(A_CTRL, 32'h8000_0000);
        push(32'hCAFE, 1'b1);
        wr(A_WMBX, req_word(2, 0));
        wr(A_WMBX, 32'd2);
        wr(A_CTRL, 32'h8000_0000);
        chk("R10 no start while ready", 32'(req_start), 32'h0);
        rd(A_STAT, v); chk("R10 error while ready", v, stat(0, 0, 1, 1));
        rd(A_RMBX, v); chk("R10 reply kept", v, 32'hCAFE);
        wr(A_CTRL, 32'h1);
        rd(A_STAT, v); chk("R9 abort clears ready", v, 32'h0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule